// File: doc/BRIEF.md
# Segmented Reservation-Station Entry Allocator

This block hands out free scheduler entries to a group of instructions dispatched together in one cycle. The entries are cut into equal segments, and each dispatch slot is tied to exactly one segment. The slot may only take an entry from its own segment. Each segment therefore needs only a small one-of-few picker rather than a search for several entries across the whole buffer. The price is that a slot whose segment is full cannot be served, even when free entries sit in other segments.

The allocator keeps the availability vector of the whole buffer as internal state, with one bit per entry and a 1 meaning free. Each cycle it shows, per slot, the entry it would take and whether the allocation commits. If any requesting slot cannot be served, the group stalls as a whole and nothing commits, so dispatch stays in program order. Entries freed by the scheduler arrive on a release mask and become free again one cycle later. The scheduler guarantees that an entry is never released in the cycle in which it is granted.

Top module: `rs_seg_alloc`

## Requirements
- R1: After reset every entry is free (`avail` all ones), and with no request raised `stall` is low and every `grant_ok` bit is low.
- R2: Slot k may only receive an entry of segment k. Entry e belongs to segment e / SEG_SIZE. The slot's index is on `grant_idx[k*IDX_W +: IDX_W]`, and its upper SEG_W bits equal k.
- R3: Within its segment a slot is given the free entry with the lowest index.
- R4: A requesting slot whose segment has no free entry raises `stall`, even when other segments hold free entries.
- R5: While `stall` is high no `grant_ok` bit is set, and the next-cycle `avail` equals the current `avail` OR the current release mask.
- R6: An entry granted with `grant_ok` high reads as taken (its `avail` bit 0) in the following cycle.
- R7: Each entry set in `release_mask` reads as free in the following cycle.
- R8: A slot with `disp_valid` low gets `grant_ok` low and takes no entry from its segment.
- R9: A slot is only granted an entry whose `avail` bit is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | NUM_SEG | Dispatch request per slot; slot k is bound to segment k |
| release_mask | input | NUM_ENT | Entries freed this cycle, one bit per entry |
| grant_ok | output | NUM_SEG | Slot k's allocation commits this cycle |
| grant_idx | output | NUM_SEG*IDX_W | Entry index per slot, slot k at bits [k*IDX_W +: IDX_W] |
| stall | output | 1 | A requesting slot found its segment full; nothing commits |
| avail | output | NUM_ENT | Current availability vector, 1 = free |

## Verification
`grant_ok`, `grant_idx` and `stall` are combinational from the registered availability and the current requests, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples these outputs one nanosecond later. `avail` is registered, so the effect of a grant or release is due one rising edge later. The bench samples it one nanosecond after that edge, before the next stimulus is applied. A bench-side availability model, built only from the requirement rules, supplies the expected pick per segment and the expected next vector.

// File: rtl/rs_alloc_pkg.sv
// Package: shared default geometry for the segmented entry allocator.
// Assumes segment count and segment size are powers of two, both >= 2.
package rs_alloc_pkg;
    localparam int unsigned DEF_NUM_SEG  = 4;
    localparam int unsigned DEF_SEG_SIZE = 4;
endpackage

// File: rtl/seg_picker.sv
// seg_picker: finds the lowest-index set bit of a segment's free vector.
// Assumes: SEG_SIZE >= 2. 'off' is only meaningful when 'found' is high.
module seg_picker #(
    parameter int unsigned SEG_SIZE = 4,
    localparam int unsigned OFF_W   = $clog2(SEG_SIZE)
) (
    input  logic [SEG_SIZE-1:0] free_vec,
    output logic                found,
    output logic [OFF_W-1:0]    off
);
    // Priority scan: walk from the top so the lowest free bit wins last.
    always_comb begin
        found = |free_vec;
        off   = '0;
        for (int i = SEG_SIZE - 1; i >= 0; i--) begin
            if (free_vec[i]) off = OFF_W'(i);
        end
    end
endmodule

// File: rtl/avail_tracker.sv
// avail_tracker: holds the entry availability vector (1 = free).
// Assumes: an entry is never allocated and released in the same cycle.
module avail_tracker #(
    parameter int unsigned NUM_ENT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ENT-1:0] alloc_mask,
    input  logic [NUM_ENT-1:0] release_mask,
    output logic [NUM_ENT-1:0] avail_q
);
    // State update: clear committed grants, set released entries.
    always_ff @(posedge clk) begin
        if (!rst_n) avail_q <= '1;
        else        avail_q <= (avail_q & ~alloc_mask) | release_mask;
    end
endmodule

// File: rtl/rs_seg_alloc.sv
// rs_seg_alloc: per-slot segmented allocator for scheduler entries.
// Slot k picks the lowest free entry of segment k. If any requesting slot's
// segment is full, stall is raised and no slot commits this cycle.
// Assumes: release_mask never names an entry granted in the same cycle.
module rs_seg_alloc #(
    parameter int unsigned NUM_SEG  = rs_alloc_pkg::DEF_NUM_SEG,
    parameter int unsigned SEG_SIZE = rs_alloc_pkg::DEF_SEG_SIZE,
    localparam int unsigned NUM_ENT = NUM_SEG * SEG_SIZE,
    localparam int unsigned SEG_W   = $clog2(NUM_SEG),
    localparam int unsigned OFF_W   = $clog2(SEG_SIZE),
    localparam int unsigned IDX_W   = SEG_W + OFF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SEG-1:0]       disp_valid,
    input  logic [NUM_ENT-1:0]       release_mask,
    output logic [NUM_SEG-1:0]       grant_ok,
    output logic [NUM_SEG*IDX_W-1:0] grant_idx,
    output logic                     stall,
    output logic [NUM_ENT-1:0]       avail
);
    logic [NUM_ENT-1:0] avail_q;
    logic [NUM_ENT-1:0] alloc_mask;
    logic [NUM_SEG-1:0] seg_found;
    logic [NUM_SEG-1:0] seg_miss;
    logic [OFF_W-1:0]   seg_off [NUM_SEG];

    avail_tracker #(.NUM_ENT(NUM_ENT)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_mask   (alloc_mask),
        .release_mask (release_mask),
        .avail_q      (avail_q)
    );

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        localparam logic [SEG_W-1:0] SEG_ID = SEG_W'(s);

        seg_picker #(.SEG_SIZE(SEG_SIZE)) u_pick (
            .free_vec (avail_q[s*SEG_SIZE +: SEG_SIZE]),
            .found    (seg_found[s]),
            .off      (seg_off[s])
        );

        // A requesting slot with an empty segment blocks the group.
        assign seg_miss[s] = disp_valid[s] & ~seg_found[s];
        // Global index = segment number followed by offset in segment.
        assign grant_idx[s*IDX_W +: IDX_W] = {SEG_ID, seg_off[s]};

        for (genvar o = 0; o < SEG_SIZE; o++) begin : g_ent
            // One-hot decode of the committed pick into the clear mask.
            assign alloc_mask[s*SEG_SIZE + o] =
                grant_ok[s] && (seg_off[s] == OFF_W'(o));
        end
    end

    // Group decision: all requesters commit or none does.
    assign stall    = |seg_miss;
    assign grant_ok = disp_valid & seg_found & {NUM_SEG{~stall}};
    assign avail    = avail_q;
endmodule

// File: rtl/rs_seg_alloc_chk.sv
// rs_seg_alloc_chk: property checker bound to rs_seg_alloc.
// Observes only the top-level ports.
module rs_seg_alloc_chk #(
    parameter int unsigned NUM_SEG  = 4,
    parameter int unsigned SEG_SIZE = 4,
    localparam int unsigned NUM_ENT = NUM_SEG * SEG_SIZE,
    localparam int unsigned SEG_W   = $clog2(NUM_SEG),
    localparam int unsigned OFF_W   = $clog2(SEG_SIZE),
    localparam int unsigned IDX_W   = SEG_W + OFF_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_SEG-1:0]       disp_valid,
    input logic [NUM_ENT-1:0]       release_mask,
    input logic [NUM_SEG-1:0]       grant_ok,
    input logic [NUM_SEG*IDX_W-1:0] grant_idx,
    input logic                     stall,
    input logic [NUM_ENT-1:0]       avail
);
    // R5
    stall_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (grant_ok == '0));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (avail == ($past(avail) | $past(release_mask))));

    for (genvar k = 0; k < NUM_SEG; k++) begin : g_slot
        // R2
        grant_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant_ok[k] |-> (grant_idx[k*IDX_W + OFF_W +: SEG_W] == SEG_W'(k)));

        // R9
        grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant_ok[k] |-> avail[grant_idx[k*IDX_W +: IDX_W]]);

        // R8
        idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !disp_valid[k] |-> !grant_ok[k]);

        // R6
        alloc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant_ok[k] |=> !avail[$past(grant_idx[k*IDX_W +: IDX_W])]);
    end
endmodule

bind rs_seg_alloc rs_seg_alloc_chk #(
    .NUM_SEG  (NUM_SEG),
    .SEG_SIZE (SEG_SIZE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .disp_valid   (disp_valid),
    .release_mask (release_mask),
    .grant_ok     (grant_ok),
    .grant_idx    (grant_idx),
    .stall        (stall),
    .avail        (avail)
);

// File: tb/rs_seg_alloc_bench.sv
// Directed bench for rs_seg_alloc: one task per scenario.
module rs_seg_alloc_bench;
    localparam int NS = 4, SS = 4, NE = 16, IW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NS-1:0]  disp_valid = '0;
    logic [NE-1:0]  release_mask = '0;
    logic [NS-1:0]  grant_ok;
    logic [NS*IW-1:0] grant_idx;
    logic           stall;
    logic [NE-1:0]  avail;

    int checks = 0;
    int failures = 0;
    logic [NE-1:0] model;

    always #2 clk = ~clk;

    rs_seg_alloc u_rs_seg_alloc (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid),
        .release_mask(release_mask), .grant_ok(grant_ok),
        .grant_idx(grant_idx), .stall(stall), .avail(avail)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, check combinational results,
    // then check the registered vector after the rising edge.
    task automatic step(input logic [NS-1:0] v, input logic [NE-1:0] rel,
                        input string req);
        logic [NE-1:0] alloc;
        logic          exp_stall;
        logic [NS-1:0] has_free;
        int            pick [NS];
        @(negedge clk);
        disp_valid   = v;
        release_mask = rel;
        #1;
        exp_stall = 1'b0;
        alloc = '0;
        for (int k = 0; k < NS; k++) begin
            pick[k] = 0;
            has_free[k] = 1'b0;
            for (int o = SS - 1; o >= 0; o--) begin
                if (model[k*SS + o]) begin
                    pick[k] = k*SS + o;
                    has_free[k] = 1'b1;
                end
            end
            if (v[k] && !has_free[k]) exp_stall = 1'b1;
        end
        check({req, " R4 stall"}, int'(stall), int'(exp_stall));
        for (int k = 0; k < NS; k++) begin
            logic exp_ok;
            exp_ok = v[k] && has_free[k] && !exp_stall;
            check({req, " R5/R8 grant_ok"}, int'(grant_ok[k]), int'(exp_ok));
            if (exp_ok) begin
                check({req, " R2/R3 grant_idx"},
                      int'(grant_idx[k*IW +: IW]), pick[k]);
                alloc[pick[k]] = 1'b1;
            end
        end
        model = (model & ~alloc) | rel;
        @(posedge clk);
        #1;
        check({req, " R6/R7 avail"}, int'(avail), int'(model));
        disp_valid   = '0;
        release_mask = '0;
    endtask

    // R1: reset state, no requests.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        model = '1;
        check("R1 avail after reset", int'(avail), 32'hFFFF);
        check("R1 stall idle", int'(stall), 0);
        check("R1 grant_ok idle", int'(grant_ok), 0);
    endtask

    // R2 R3 R6: all slots dispatch twice; picks 0,4,8,12 then 1,5,9,13.
    task automatic t_full_group();
        step(4'b1111, '0, "full1");
        check("R6 avail after first group", int'(avail), 32'hEEEE);
        step(4'b1111, '0, "full2");
        check("R6 avail after second group", int'(avail), 32'hCCCC);
    endtask

    // R8: only slots 0 and 2 request; segments 1 and 3 untouched.
    task automatic t_partial();
        step(4'b0101, '0, "partial");
        check("R8 idle segments unchanged", int'(avail), 32'hC8C8);
    endtask

    // R4 R5: drain segment 0, then a full group must stall.
    task automatic t_segment_full();
        step(4'b0001, '0, "drain0");
        check("R3 last entry of seg0", int'(avail), 32'hC8C0);
        step(4'b1111, '0, "stall");
        check("R5 avail held under stall", int'(avail), 32'hC8C0);
    endtask

    // R7 R3: releases, including one concurrent with an allocation.
    task automatic t_release();
        step(4'b0000, 16'h000F, "rel0");
        check("R7 seg0 refilled", int'(avail), 32'hC8CF);
        step(4'b0100, 16'h1000, "alloc+rel");
        check("R7 concurrent release", int'(avail), 32'hD0CF);
        step(4'b1000, '0, "lowest after rel");
        check("R3 picked released entry 12", int'(avail), 32'hC0CF);
        step(4'b0100, 16'h0100, "stall+rel");
        check("R5 release under stall", int'(avail), 32'hC1CF);
    endtask

    initial begin
        t_reset();
        t_full_group();
        t_partial();
        t_segment_full();
        t_release();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule